// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register file of a processor core that runs in several privilege modes. It holds sixteen architectural registers of `DW` bits. It serves two combinational read ports and one synchronous write port, all addressed by architectural register number. Some registers have more than one physical copy. The current privilege mode decides which copy an access reaches, so an exception handler gets its own stack pointer and link register without any save or restore. The fast-interrupt mode also gets private copies of registers 8 to 12.

The block also holds one saved status word for each exception mode. The saved status word follows the current mode in the same way. The mode itself is held in a register inside the block. The surrounding core loads it through a set strobe. Banking works by steering each address to a physical slot chosen by the current bank, so no data moves when the mode changes.

Top module: `banked_regfile`

## Requirements
- R1: During synchronous reset (`rst` high at a clock edge), every physical register copy and every saved status word clears to 0, and the mode register loads system mode (5'h1F). After reset every architectural read returns 0.
- R2: Registers 0 to 7 and register 15 each have a single physical copy. A value written to them in any mode is read back the same in every mode.
- R3: Registers 8 to 12 have two copies. Fast-interrupt mode (5'h11) uses one copy, and all other modes share the other. Switching between two modes that are not fast-interrupt never changes what registers 8 to 12 return.
- R4: Registers 13 and 14 have one copy per bank. The banks are: user 5'h10 and system 5'h1F share bank 0; fast-interrupt 5'h11 is bank 1; interrupt 5'h12 is bank 2; supervisor 5'h13 is bank 3; abort 5'h17 is bank 4; undefined 5'h1B is bank 5.
- R5: Each of banks 1 to 5 owns one saved status word. It is read on `sts_rd_data` and written by `sts_wr_en` in that bank's modes. In bank 0, `sts_rd_data` is 0 and status writes are dropped.
- R6: A mode value outside the seven listed encodings selects bank 0. It behaves like user mode for both register and status accesses.
- R7: A mode set (`mode_set_en`) takes effect at the next clock edge and is shown on `cur_mode`. A register write or status write in the same cycle as a mode set goes to the bank of the mode in effect before the change.
- R8: Reads are combinational on the current mode. A read of the register being written in the same cycle returns the old value, and the new value appears from the next cycle.
- R9: Setting the mode that is already in effect, or moving between user and system modes, leaves every visible register and the status read value unchanged.
- R10: The two read ports are independent. Each returns the register at its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_set_en | input | 1 | Load a new privilege mode at this edge |
| mode_set_val | input | 5 | Mode value to load |
| cur_mode | output | 5 | Mode currently in effect |
| rd_a_addr | input | 4 | Read port A register number |
| rd_a_data | output | DW | Read port A data |
| rd_b_addr | input | 4 | Read port B register number |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register number to write |
| wr_data | input | DW | Register write data |
| sts_wr_en | input | 1 | Saved status write enable |
| sts_wr_data | input | DW | Saved status write data |
| sts_rd_data | output | DW | Saved status word of the current bank |

## Verification
The bench builds the block with its default width of 32 bits. At that width the 31 physical register slots and 5 status words are small enough to be covered exhaustively. Thousands of random steps visit every bank pair many times, including fast-interrupt to interrupt and user to system, and each address range is checked against a per-bank model. Random 32-bit data also makes a stale or wrong-bank value easy to tell apart from the expected one.

// File: rtl/bregs_pkg.sv
package bregs_pkg;

    localparam int NREG    = 16;
    localparam int AW      = 4;
    localparam int MODE_W  = 5;
    localparam int NBANK   = 6;
    localparam int BANK_W  = 3;
    localparam int NCOMMON = 9;            // r0..r7 and r15
    localparam int NHI     = 5;            // r8..r12
    localparam int NSL     = 2;            // r13, r14
    localparam int HI_BASE = NCOMMON;
    localparam int SL_BASE = NCOMMON + 2 * NHI;
    localparam int NPHYS   = SL_BASE + NBANK * NSL;
    localparam int SLOT_W  = $clog2(NPHYS);

    typedef enum logic [MODE_W-1:0] {
        MD_USR = 5'h10,
        MD_FIQ = 5'h11,
        MD_IRQ = 5'h12,
        MD_SVC = 5'h13,
        MD_ABT = 5'h17,
        MD_UND = 5'h1B,
        MD_SYS = 5'h1F
    } mode_e;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [SLOT_W-1:0] slot_t;

    localparam bank_t BK_NONE = 3'd0;
    localparam bank_t BK_FIQ  = 3'd1;
    localparam bank_t BK_IRQ  = 3'd2;
    localparam bank_t BK_SVC  = 3'd3;
    localparam bank_t BK_ABT  = 3'd4;
    localparam bank_t BK_UND  = 3'd5;

    typedef struct packed {
        logic  en;
        slot_t slot;
    } phys_wr_t;

    function automatic bank_t bank_of(logic [MODE_W-1:0] m);
        case (m)
            MD_FIQ:  return BK_FIQ;
            MD_IRQ:  return BK_IRQ;
            MD_SVC:  return BK_SVC;
            MD_ABT:  return BK_ABT;
            MD_UND:  return BK_UND;
            default: return BK_NONE;   // user, system, unknown
        endcase
    endfunction

    function automatic slot_t slot_of(logic [AW-1:0] a, bank_t b);
        int s;
        int ai;
        ai = int'(a);
        if (ai < 8)
            s = ai;
        else if (ai == NREG - 1)
            s = 8;
        else if (ai < 13)
            s = HI_BASE + (ai - 8) + ((b == BK_FIQ) ? NHI : 0);
        else
            s = SL_BASE + int'(b) * NSL + (ai - 13);
        return slot_t'(s);
    endfunction

endpackage

// File: rtl/bregs_steer.sv
module bregs_steer
    import bregs_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  bank_t         bank,
    output slot_t         slot
);
    always_comb slot = slot_of(addr, bank);
endmodule

// File: rtl/bregs_store.sv
module bregs_store
    import bregs_pkg::*;
#(
    parameter int DW = 32,
    parameter int N  = NPHYS
) (
    input  logic          clk,
    input  logic          rst,
    input  phys_wr_t      wr,
    input  logic [DW-1:0] wr_data,
    input  slot_t         ra_slot,
    output logic [DW-1:0] ra_data,
    input  slot_t         rb_slot,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (wr.en) begin
            mem[wr.slot] <= wr_data;
        end
    end

    always_comb begin
        ra_data = mem[ra_slot];
        rb_data = mem[rb_slot];
    end
endmodule

// File: rtl/bregs_ssr.sv
module bregs_ssr
    import bregs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  bank_t         bank,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] sv [NBANK];

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_word
            if (g == 0) begin : g_none
                always_ff @(posedge clk) sv[g] <= '0;
            end else begin : g_bank
                always_ff @(posedge clk) begin
                    if (rst)
                        sv[g] <= '0;
                    else if (wr_en && bank == bank_t'(g))
                        sv[g] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb rd_data = (bank == BK_NONE) ? '0 : sv[bank];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bregs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_set_en,
    input  logic [MODE_W-1:0] mode_set_val,
    output logic [MODE_W-1:0] cur_mode,
    input  logic [AW-1:0]     rd_a_addr,
    output logic [DW-1:0]     rd_a_data,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [DW-1:0]     rd_b_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              sts_wr_en,
    input  logic [DW-1:0]     sts_wr_data,
    output logic [DW-1:0]     sts_rd_data
);
    localparam int NPORT = 3;   // read A, read B, write

    logic [MODE_W-1:0] mode_q;
    bank_t             bank_cur;
    logic [AW-1:0]     port_addr [NPORT];
    slot_t             port_slot [NPORT];
    phys_wr_t          wr_cmd;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MD_SYS;
        else if (mode_set_en)
            mode_q <= mode_set_val;
    end

    assign cur_mode = mode_q;
    assign bank_cur = bank_of(mode_q);

    assign port_addr[0] = rd_a_addr;
    assign port_addr[1] = rd_b_addr;
    assign port_addr[2] = wr_addr;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_steer
            bregs_steer u_steer (
                .addr (port_addr[p]),
                .bank (bank_cur),
                .slot (port_slot[p])
            );
        end
    endgenerate

    assign wr_cmd.en   = wr_en;
    assign wr_cmd.slot = port_slot[2];

    bregs_store #(.DW(DW), .N(NPHYS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_cmd),
        .wr_data (wr_data),
        .ra_slot (port_slot[0]),
        .ra_data (rd_a_data),
        .rb_slot (port_slot[1]),
        .rb_data (rd_b_data)
    );

    bregs_ssr #(.DW(DW)) u_ssr (
        .clk     (clk),
        .rst     (rst),
        .bank    (bank_cur),
        .wr_en   (sts_wr_en),
        .wr_data (sts_wr_data),
        .rd_data (sts_rd_data)
    );
endmodule

// File: rtl/bregs_chk.sv
module bregs_chk
    import bregs_pkg::*;
#(
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_set_en,
    input logic [MODE_W-1:0] mode_set_val,
    input logic [MODE_W-1:0] cur_mode,
    input logic [AW-1:0]     rd_a_addr,
    input logic [DW-1:0]     rd_a_data,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic              sts_wr_en,
    input logic [DW-1:0]     sts_rd_data
);
    // R7
    mode_load_chk: assert property (@(posedge clk) disable iff (rst)
        mode_set_en |=> cur_mode == $past(mode_set_val));

    // R5
    ssr_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_of(cur_mode) == BK_NONE) |-> sts_rd_data == '0);

    // R2
    shared_readback_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en) &&
         ($past(wr_addr) < 4'd8 || $past(wr_addr) == 4'd15) &&
         rd_a_addr == $past(wr_addr))
        |-> rd_a_data == $past(wr_data));

    // R9
    same_bank_reg_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(wr_en) && $stable(rd_a_addr) &&
         bank_of($past(cur_mode)) == bank_of(cur_mode))
        |-> $stable(rd_a_data));

    // R9
    same_bank_sts_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(sts_wr_en) &&
         bank_of($past(cur_mode)) == bank_of(cur_mode))
        |-> $stable(sts_rd_data));
endmodule

bind banked_regfile bregs_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_set_en  (mode_set_en),
    .mode_set_val (mode_set_val),
    .cur_mode     (cur_mode),
    .rd_a_addr    (rd_a_addr),
    .rd_a_data    (rd_a_data),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .sts_wr_en    (sts_wr_en),
    .sts_rd_data  (sts_rd_data)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_set_en = 1'b0;
    logic [4:0]    mode_set_val = 5'h1F;
    logic [4:0]    cur_mode;
    logic [3:0]    rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, sts_wr_en = 1'b0;
    logic [DW-1:0] sts_wr_data = '0, sts_rd_data;

    always #10 clk = ~clk;

    banked_regfile #(.DW(DW)) u0 (.*);

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model: separate storage per bank
    logic [DW-1:0] m_cmn [16];
    logic [DW-1:0] m_hi  [2][5];
    logic [DW-1:0] m_sl  [6][2];
    logic [DW-1:0] m_ss  [6];
    logic [4:0]    m_mode;

    function automatic int mbank(logic [4:0] m);
        if (m == 5'h11) return 1;
        if (m == 5'h12) return 2;
        if (m == 5'h13) return 3;
        if (m == 5'h17) return 4;
        if (m == 5'h1B) return 5;
        return 0;
    endfunction

    function automatic logic [DW-1:0] mread(int a, int bk);
        if (a < 8 || a == 15) return m_cmn[a];
        if (a <= 12) return m_hi[(bk == 1) ? 1 : 0][a-8];
        return m_sl[bk][a-13];
    endfunction

    function automatic string rtag(int a);
        if (a < 8 || a == 15) return "R2";
        if (a <= 12) return "R3";
        return "R4";
    endfunction

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_cmn[i] = '0;
        for (int i = 0; i < 2; i++) for (int j = 0; j < 5; j++) m_hi[i][j] = '0;
        for (int i = 0; i < 6; i++) begin
            m_sl[i][0] = '0; m_sl[i][1] = '0; m_ss[i] = '0;
        end
        m_mode = 5'h1F;
    endtask

    // one cycle: drive at negedge, compare combinational reads, advance model at posedge
    task automatic step(bit we, logic [3:0] wa, logic [DW-1:0] wd,
                        bit se, logic [DW-1:0] sd,
                        bit me, logic [4:0] mv,
                        logic [3:0] a, logic [3:0] b, string tag);
        int bk;
        wr_en = we; wr_addr = wa; wr_data = wd;
        sts_wr_en = se; sts_wr_data = sd;
        mode_set_en = me; mode_set_val = mv;
        rd_a_addr = a; rd_b_addr = b;
        #1;
        bk = mbank(m_mode);
        chk((tag != "") ? tag : rtag(int'(a)), "port A", rd_a_data, mread(int'(a), bk));
        chk((tag != "") ? tag : "R10", "port B", rd_b_data, mread(int'(b), bk));
        chk((tag != "") ? tag : "R5", "status", sts_rd_data, (bk == 0) ? '0 : m_ss[bk]);
        chk((tag != "") ? tag : "R7", "mode", {27'd0, cur_mode}, {27'd0, m_mode});
        @(posedge clk);
        if (we) begin
            if (wa < 8 || wa == 15) m_cmn[wa] = wd;
            else if (wa <= 12) m_hi[(bk == 1) ? 1 : 0][wa-8] = wd;
            else m_sl[bk][wa-13] = wd;
        end
        if (se && bk != 0) m_ss[bk] = sd;
        if (me) m_mode = mv;
        @(negedge clk);
    endtask

    task automatic setm(logic [4:0] m, string tag);
        step(0, 0, 0, 0, 0, 1, m, 0, 0, tag);
    endtask

    localparam logic [4:0] MODES [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

    initial begin
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything reads zero, system mode
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 0, 0, 4'(i), 4'(15 - i), "R1");

        // R3/R4: fill each bank's r8..r14, then read all back
        for (int m = 0; m < 7; m++) begin
            setm(MODES[m], "R4");
            for (int r = 8; r < 15; r++)
                step(1, 4'(r), $urandom, 1, $urandom, 0, 0, 4'(r), 4'(r), "");
        end
        for (int m = 0; m < 7; m++) begin
            setm(MODES[m], "R4");
            for (int r = 8; r < 15; r++) step(0, 0, 0, 0, 0, 0, 0, 4'(r), 4'(r - 1), "");
        end

        // R3: interrupt <-> fast-interrupt transitions
        setm(5'h12, "R3");
        step(1, 4'd9, 32'hA5A5_0009, 0, 0, 1, 5'h11, 4'd9, 4'd13, "R7");
        step(1, 4'd9, 32'h5A5A_1109, 0, 0, 1, 5'h12, 4'd9, 4'd13, "R3");
        step(0, 0, 0, 0, 0, 1, 5'h13, 4'd9, 4'd13, "R3");
        step(0, 0, 0, 0, 0, 0, 0, 4'd9, 4'd14, "R3");

        // R6: unknown encoding behaves as bank 0
        setm(5'h10, "R6");
        step(1, 4'd13, 32'hDEAD_0013, 1, 32'hFFFF_FFFF, 1, 5'h05, 4'd13, 4'd8, "R6");
        step(1, 4'd14, 32'hBEEF_0014, 1, 32'h1234_5678, 0, 0, 4'd13, 4'd14, "R6");
        step(0, 0, 0, 0, 0, 1, 5'h1F, 4'd14, 4'd13, "R6");

        // R9: user <-> system and same-mode set leave everything as it was
        step(0, 0, 0, 0, 0, 1, 5'h10, 4'd13, 4'd12, "R9");
        step(0, 0, 0, 0, 0, 1, 5'h10, 4'd14, 4'd8, "R9");
        step(0, 0, 0, 0, 0, 1, 5'h1F, 4'd13, 4'd14, "R9");
        setm(5'h13, "R9");
        step(0, 0, 0, 0, 0, 1, 5'h13, 4'd13, 4'd14, "R9");

        // R8: read during write returns old value
        step(1, 4'd3, 32'h0303_0303, 0, 0, 0, 0, 4'd3, 4'd3, "R8");
        step(1, 4'd3, 32'h3030_3030, 0, 0, 0, 0, 4'd3, 4'd3, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 4'd3, 4'd15, "R8");

        // random mix of writes and mode changes
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] mv;
            logic [3:0] wa;
            mv = ($urandom_range(0, 15) == 0) ? 5'($urandom) : MODES[$urandom_range(0, 6)];
            wa = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'($urandom_range(8, 14));
            step($urandom_range(0, 1), wa, $urandom,
                 $urandom_range(0, 3) == 0, $urandom,
                 $urandom_range(0, 3) == 0, mv,
                 4'($urandom), 4'($urandom_range(8, 14)), "");
        end

        // R1: reset again clears all copies
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < 7; m++) begin
            setm(MODES[m], "R1");
            for (int r = 8; r < 15; r++) step(0, 0, 0, 0, 0, 0, 0, 4'(r), 4'(r - 8), "R1");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule